// File: doc/BRIEF.md
# External Interrupt Sense Unit

This block turns one external interrupt pin into an interrupt request for a processor's interrupt controller. A two-bit sense code selects the trigger. The trigger can be a low level on the pin, a falling edge or a rising edge, and one code is reserved and stays silent. The pin is first brought into the system clock domain by a synchroniser. The detectors then work only on the synchronised value. In the edge modes a pending flag holds the request until the interrupt controller acknowledges it. In the level mode the request simply follows the pin.

A second path runs from a slow always-on oscillator clock. It serves the case where the system clock has been stopped for power-down. It has its own synchroniser and keeps a short history of slow-clock samples. It raises a wake request only when the low-level mode is selected and the pin was low on two successive slow samples. Edge modes cannot wake the device in this state.

Top module: `ext_irq_sense`

## Requirements
- R1: With sense code 2'b00, irq_pending is high exactly while the synchronised pin is low, two system clock edges behind the pin. It is not latched, so it drops when the pin returns high.
- R2: With sense code 2'b10, a high-to-low transition of the pin sets irq_pending. A low-to-high transition does not.
- R3: With sense code 2'b11, a low-to-high transition of the pin sets irq_pending. A high-to-low transition does not.
- R4: Sense code 2'b01 is reserved. In it irq_pending stays low whatever the pin does.
- R5: In the edge modes irq_pending stays high until irq_ack is sampled high in a cycle with no new edge. It is low from the following cycle.
- R6: If a new edge and irq_ack fall in the same cycle, the new edge wins and irq_pending stays high.
- R7: In the edge modes, a pin pulse longer than one system clock period sets irq_pending.
- R8: Any change of the sense code clears the edge pending flag and re-arms the edge history. No request appears after the change without a real edge that follows it.
- R9: With clk_stopped high and sense code 2'b00, a pin low on two successive slow-clock samples raises wake_req. wake_req drops again once the pin has been back high for two slow samples.
- R10: A low seen on only one slow-clock sample never raises wake_req.
- R11: wake_req stays low in every sense mode other than 2'b00, and whenever clk_stopped is low.
- R12: After reset, irq_pending and wake_req are low. A reset also discards a pending edge request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| slow_clk | input | 1 | Always-on slow oscillator clock for wake qualification |
| rst_n | input | 1 | Synchronous active-low reset, sampled in both clock domains |
| pin_in | input | 1 | Asynchronous external interrupt pin |
| sense_mode | input | 2 | Trigger select: 00 low level, 01 reserved, 10 falling edge, 11 rising edge |
| irq_ack | input | 1 | Acknowledge pulse that clears an edge request |
| clk_stopped | input | 1 | High while the system clock is stopped for power-down |
| irq_pending | output | 1 | Interrupt request to the interrupt controller |
| wake_req | output | 1 | Wake request from the slow-clock qualifier |

## Verification
An acknowledge from the interrupt controller can land in the same system clock cycle as a fresh edge. The bench provokes this by counting the two synchroniser edges after a pin change, then raising irq_ack for exactly the cycle in which the edge detector fires. It judges the result by irq_pending staying high afterwards. The pending flag can also be cleared by a sense-code change while it is set, and the bench judges that by irq_pending dropping with no acknowledge given.

// File: rtl/ext_irq_pkg.sv
// Shared types for the external interrupt sense unit.
// Assumes: the sense code is a two-bit field decoded exactly as enumerated here.
package ext_irq_pkg;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_RSVD = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_e;

    // True for the two codes that detect transitions.
    function automatic logic is_edge_mode(input sense_e m);
        return (m == SENSE_FALL) || (m == SENSE_RISE);
    endfunction

endpackage

// File: rtl/ext_irq_sync.sv
// Multi-flop synchroniser for one asynchronous bit.
// Assumes: STAGES >= 1; RESET_VAL is the idle level of the input, so reset
// never presents a false transition downstream.
module ext_irq_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            // Single capture flop.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= RESET_VAL;
                else        chain <= d;
            end
        end else begin : g_chain
            // Shift the input through the flop chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= {STAGES{RESET_VAL}};
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/ext_irq_edge_track.sv
// Edge detector and pending flag for the edge sense modes.
// Assumes: pin_s is already synchronous to clk. A change of sense_mode
// suppresses detection for one cycle and clears the flag; a new edge beats
// an acknowledge in the same cycle.
module ext_irq_edge_track
    import ext_irq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   pin_s,
    input  sense_e sense_mode,
    input  logic   irq_ack,
    output logic   edge_hit,
    output logic   edge_flag
);

    sense_e mode_q;
    logic   pin_d;
    logic   mode_chg;
    logic   fell;
    logic   rose;

    assign mode_chg = (sense_mode != mode_q);
    assign fell     = pin_d & ~pin_s;
    assign rose     = ~pin_d & pin_s;

    // Select the transition that the current code asks for.
    always_comb begin
        edge_hit = 1'b0;
        if (!mode_chg) begin
            case (sense_mode)
                SENSE_FALL: edge_hit = fell;
                SENSE_RISE: edge_hit = rose;
                default:    edge_hit = 1'b0;
            endcase
        end
    end

    // Remember the previous code, to spot a code change.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= SENSE_LOW;
        else        mode_q <= sense_mode;
    end

    // Edge history: the previous synchronised pin value.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_d <= 1'b1;
        else        pin_d <= pin_s;
    end

    // Pending flag: a code change clears it, an edge sets it, an ack clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 edge_flag <= 1'b0;
        else if (mode_chg || !is_edge_mode(sense_mode)) edge_flag <= 1'b0;
        else if (edge_hit)                          edge_flag <= 1'b1;
        else if (irq_ack)                           edge_flag <= 1'b0;
    end

endmodule

// File: rtl/ext_irq_wake_qual.sv
// Wake qualifier running on the slow always-on clock.
// Assumes: CONFIRM >= 2; sense_mode and clk_stopped are quasi-static while
// the system clock is stopped; rst_n is held across at least one slow edge.
module ext_irq_wake_qual
    import ext_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CONFIRM     = 2
) (
    input  logic   slow_clk,
    input  logic   rst_n,
    input  logic   pin_in,
    input  logic   clk_stopped,
    input  sense_e sense_mode,
    output logic   wake_req
);

    logic               pin_w;
    logic [CONFIRM-1:0] hist;

    ext_irq_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) i_wake_sync (
        .clk   (slow_clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_w)
    );

    // Keep the last CONFIRM synchronised samples.
    always_ff @(posedge slow_clk) begin
        if (!rst_n) hist <= '1;
        else        hist <= {hist[CONFIRM-2:0], pin_w};
    end

    // Wake only in level mode, with the clock stopped and all samples low.
    always_ff @(posedge slow_clk) begin
        if (!rst_n) wake_req <= 1'b0;
        else        wake_req <= clk_stopped && (sense_mode == SENSE_LOW) && !(|hist);
    end

endmodule

// File: rtl/ext_irq_sense.sv
// External interrupt sense unit: synchronises one pin, decodes the sense
// code into a level or edge request, and qualifies a low-level wake on a
// slow clock while the system clock is stopped.
// Assumes: rst_n is synchronous to both clocks and long enough for both.
module ext_irq_sense
    import ext_irq_pkg::*;
#(
    parameter int SYNC_STAGES      = 2,
    parameter int WAKE_SYNC_STAGES = 2,
    parameter int WAKE_CONFIRM     = 2
) (
    input  logic       clk,
    input  logic       slow_clk,
    input  logic       rst_n,
    input  logic       pin_in,
    input  logic [1:0] sense_mode,
    input  logic       irq_ack,
    input  logic       clk_stopped,
    output logic       irq_pending,
    output logic       wake_req
);

    sense_e mode;
    logic   pin_s;
    logic   edge_hit;
    logic   edge_flag;

    assign mode = sense_e'(sense_mode);

    ext_irq_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) i_pin_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_s)
    );

    ext_irq_edge_track i_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_s      (pin_s),
        .sense_mode (mode),
        .irq_ack    (irq_ack),
        .edge_hit   (edge_hit),
        .edge_flag  (edge_flag)
    );

    // Route the request source selected by the sense code.
    always_comb begin
        case (mode)
            SENSE_LOW:  irq_pending = ~pin_s;
            SENSE_FALL,
            SENSE_RISE: irq_pending = edge_flag;
            default:    irq_pending = 1'b0;
        endcase
    end

    ext_irq_wake_qual #(
        .SYNC_STAGES (WAKE_SYNC_STAGES),
        .CONFIRM     (WAKE_CONFIRM)
    ) i_wake (
        .slow_clk    (slow_clk),
        .rst_n       (rst_n),
        .pin_in      (pin_in),
        .clk_stopped (clk_stopped),
        .sense_mode  (mode),
        .wake_req    (wake_req)
    );

endmodule

// File: rtl/ext_irq_sense_chk.sv
// Property checker for ext_irq_sense, attached by bind.
// Assumes: default parameters (two-flop synchronisers, two-sample wake
// confirmation), which fix the latencies used below.
module ext_irq_sense_chk (
    input logic       clk,
    input logic       slow_clk,
    input logic       rst_n,
    input logic       pin_in,
    input logic [1:0] sense_mode,
    input logic       irq_ack,
    input logic       clk_stopped,
    input logic       irq_pending,
    input logic       wake_req,
    input logic       edge_hit
);

    logic [2:0] fast_age;
    logic [2:0] slow_age;

    // Count system cycles since reset, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)              fast_age <= '0;
        else if (fast_age != 3'd7) fast_age <= fast_age + 3'd1;
    end

    // Count slow cycles since reset, saturating.
    always_ff @(posedge slow_clk) begin
        if (!rst_n)              slow_age <= '0;
        else if (slow_age != 3'd7) slow_age <= slow_age + 3'd1;
    end

    assert_level_follows_pin_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_age >= 3'd3 && sense_mode == 2'b00) |-> (irq_pending == !$past(pin_in, 2)));

    assert_reserved_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sense_mode == 2'b01) |-> !irq_pending);

    assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pending && irq_ack && !edge_hit && sense_mode[1])
        |=> (!irq_pending || sense_mode != $past(sense_mode)));

    assert_set_beats_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_hit && irq_ack)
        |=> (irq_pending || sense_mode != $past(sense_mode)));

    assert_no_spurious_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_pending) && sense_mode[1] && $stable(sense_mode)) |-> $past(edge_hit));

    assert_wake_two_lows_R10: assert property (@(posedge slow_clk) disable iff (!rst_n)
        (slow_age >= 3'd6 && $rose(wake_req)) |-> (!$past(pin_in, 4) && !$past(pin_in, 5)));

    assert_wake_gated_R11: assert property (@(posedge slow_clk) disable iff (!rst_n)
        (!clk_stopped || sense_mode != 2'b00) |=> !wake_req);

endmodule

bind ext_irq_sense ext_irq_sense_chk i_chk (
    .clk         (clk),
    .slow_clk    (slow_clk),
    .rst_n       (rst_n),
    .pin_in      (pin_in),
    .sense_mode  (sense_mode),
    .irq_ack     (irq_ack),
    .clk_stopped (clk_stopped),
    .irq_pending (irq_pending),
    .wake_req    (wake_req),
    .edge_hit    (edge_hit)
);

// File: tb/test_ext_irq_sense.sv
// Bench for ext_irq_sense: a vector table for the sense modes, then
// directed tests for reset, pulses, ack collision and wake qualification.
module test_ext_irq_sense;

    logic       clk = 1'b0;
    logic       slow_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_in = 1'b1;
    logic [1:0] sense_mode = 2'b11;
    logic       irq_ack = 1'b0;
    logic       clk_stopped = 1'b0;
    logic       irq_pending;
    logic       wake_req;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    bit saw_wake = 1'b0;

    ext_irq_sense i_ext_irq_sense (
        .clk         (clk),
        .slow_clk    (slow_clk),
        .rst_n       (rst_n),
        .pin_in      (pin_in),
        .sense_mode  (sense_mode),
        .irq_ack     (irq_ack),
        .clk_stopped (clk_stopped),
        .irq_pending (irq_pending),
        .wake_req    (wake_req)
    );

    // 100 MHz system clock.
    always #5 clk = ~clk;

    // Slow clock, 80 ns period, edges offset from system clock edges.
    initial begin
        #2;
        forever #40 slow_clk = ~slow_clk;
    end

    // Record any wake request seen in an observation window.
    always @(negedge clk) if (wake_req) saw_wake = 1'b1;

    task automatic check(input logic act, input logic exp, input string tag, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
        end
    endtask

    task automatic wait_slow(input int n);
        repeat (n) @(posedge slow_clk);
        #5;
    endtask

    // Vector: {req[3:0], mode[1:0], pin, ack, expected irq_pending}
    localparam int NV = 17;
    localparam logic [8:0] VEC [NV] = '{
        {4'd8, 2'b10, 1'b1, 1'b0, 1'b0},  // R8 code change, no edge
        {4'd2, 2'b10, 1'b0, 1'b0, 1'b1},  // R2 falling edge sets
        {4'd5, 2'b10, 1'b0, 1'b1, 1'b0},  // R5 ack clears
        {4'd2, 2'b10, 1'b1, 1'b0, 1'b0},  // R2 rising ignored
        {4'd3, 2'b11, 1'b1, 1'b0, 1'b0},  // R3 code change, quiet
        {4'd3, 2'b11, 1'b0, 1'b0, 1'b0},  // R3 falling ignored
        {4'd3, 2'b11, 1'b1, 1'b0, 1'b1},  // R3 rising sets
        {4'd5, 2'b11, 1'b1, 1'b0, 1'b1},  // R5 held without ack
        {4'd8, 2'b10, 1'b1, 1'b0, 1'b0},  // R8 code change clears flag
        {4'd1, 2'b00, 1'b1, 1'b0, 1'b0},  // R1 high pin, no request
        {4'd1, 2'b00, 1'b0, 1'b0, 1'b1},  // R1 low pin requests
        {4'd1, 2'b00, 1'b1, 1'b0, 1'b0},  // R1 not latched
        {4'd4, 2'b01, 1'b0, 1'b0, 1'b0},  // R4 reserved, pin low
        {4'd4, 2'b01, 1'b1, 1'b0, 1'b0},  // R4 reserved, rising
        {4'd4, 2'b01, 1'b0, 1'b0, 1'b0},  // R4 reserved, falling
        {4'd1, 2'b00, 1'b0, 1'b0, 1'b1},  // R1 low pin again
        {4'd8, 2'b10, 1'b0, 1'b0, 1'b0}   // R8 level to edge, no request
    };

    initial begin
        repeat (25) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(irq_pending, 1'b0, "R12", "irq_pending after reset");
        check(wake_req, 1'b0, "R12", "wake_req after reset");

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            sense_mode = VEC[i][4:3];
            pin_in     = VEC[i][2];
            repeat (4) @(negedge clk);
            if (VEC[i][1]) begin
                irq_ack = 1'b1;
                @(negedge clk);
                irq_ack = 1'b0;
                @(negedge clk);
            end
            check(irq_pending, VEC[i][0], $sformatf("R%0d", VEC[i][8:5]),
                  $sformatf("vector %0d", i));
        end

        // R7: pulse of 12 ns in falling-edge mode
        pin_in = 1'b1;
        repeat (4) @(negedge clk);
        pin_in = 1'b0;
        #12;
        pin_in = 1'b1;
        repeat (4) @(negedge clk);
        check(irq_pending, 1'b1, "R7", "short pulse in edge mode");
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        @(negedge clk);
        check(irq_pending, 1'b0, "R5", "ack after pulse");

        // R6: ack in the very cycle the falling edge is detected
        pin_in = 1'b0;
        @(posedge clk);
        @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        irq_ack = 1'b1;
        @(posedge clk);
        @(negedge clk);
        irq_ack = 1'b0;
        check(irq_pending, 1'b1, "R6", "edge wins over ack");
        @(negedge clk);
        check(irq_pending, 1'b1, "R6", "flag still held");

        // R12: reset drops a pending edge request
        rst_n = 1'b0;
        @(negedge clk);
        check(irq_pending, 1'b0, "R12", "reset clears pending");
        rst_n = 1'b1;
        pin_in = 1'b1;
        repeat (4) @(negedge clk);

        // R9: qualified low level wakes
        wait_slow(1);
        clk_stopped = 1'b1;
        sense_mode  = 2'b00;
        pin_in      = 1'b0;
        wait_slow(6);
        check(wake_req, 1'b1, "R9", "wake after sustained low");
        pin_in = 1'b1;
        wait_slow(6);
        check(wake_req, 1'b0, "R9", "wake released");

        // R10: low on one slow sample only
        saw_wake = 1'b0;
        pin_in = 1'b0;
        wait_slow(1);
        pin_in = 1'b1;
        wait_slow(8);
        check(saw_wake, 1'b0, "R10", "single low sample");

        // R11: edge mode cannot wake
        saw_wake = 1'b0;
        sense_mode = 2'b10;
        pin_in = 1'b0;
        wait_slow(6);
        check(saw_wake, 1'b0, "R11", "edge mode while stopped");

        // R11: clock running, level mode, no wake
        pin_in = 1'b1;
        sense_mode = 2'b00;
        clk_stopped = 1'b0;
        wait_slow(4);
        saw_wake = 1'b0;
        pin_in = 1'b0;
        wait_slow(6);
        check(saw_wake, 1'b0, "R11", "clock running");
        pin_in = 1'b1;
        wait_slow(2);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #200000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (all requirements): actual run incomplete expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule